// File: doc/BRIEF.md
# PIO Setup and Register FIS Sequencer

This block serves one port of a serial-ATA host controller. For every data-request block of a programmed-I/O command, it composes the 20-byte PIO Setup frame. It writes that frame one byte per cycle into the port's received-frame buffer and then waits for the block's data phase to be acknowledged. On request it also composes the 20-byte device-to-host register frame. It decides the interrupt flag inside each frame and raises the port's interrupt-status bits at the correct moments.

The interrupt flag of a PIO Setup frame does not depend on controller interrupt state. It depends on the command type and on whether the command has already finished a data-request block. The PIO Setup status bit is raised only once the data phase of its block is over. The first block of a packet command carries the already-staged command packet, so that block has no data phase.

Top module: `pio_fis_seq`

## Requirements
- R1: While reset is held and right after it, there are no buffer writes, `data_req_o` is low, `irq_sts_o` is 0, `irq_o` is 0, `proto_err_o` is 0 and `xfer_count_o` is 0.
- R2: An accepted data-request start writes 20 bytes to addresses PSFIS_BASE+0 through PSFIS_BASE+19, in ascending order, on consecutive cycles, starting the cycle after acceptance. The bytes are: byte 0 = 0x5F, byte 1 = interrupt flag in bit 6 (all other bits 0), byte 2 = status, byte 3 = error, bytes 16 and 17 = block byte count (low byte first). All other bytes are 0.
- R3: The interrupt flag of a PIO Setup frame is 1 when the current command has already finished a data-request block, or when the command is a non-packet read (`cmd_packet_i`=0, `cmd_write_i`=0). Otherwise the flag is 0.
- R4: The first block of a packet command gets a PIO Setup frame with flag 0. No data phase follows it (`data_req_o` stays low) and the transfer count does not change.
- R5: Status bit 1 (PIO setup done) is set in the cycle after `data_done_i` is accepted, and only if that block's frame had its flag set.
- R6: If bit 0 (error) of the status byte in a PIO Setup frame is 1, status bit 2 (task-file error) is set in the cycle after the frame's last byte is written.
- R7: A register-frame request writes 20 bytes to RFIS_BASE+0 through RFIS_BASE+19: 0x34, 0x40, status, error, then zeros. Status bit 0 is set in the cycle after the last byte.
- R8: `cmd_start_i` clears the transfer count. Each accepted `data_done_i` adds that block's byte count.
- R9: `cmd_start_i` clears the finished-block flag. Finishing any block, including a skipped packet block, sets it.
- R10: `data_req_o` is high from the cycle after a non-skipped PIO frame's last byte until the cycle in which `data_done_i` is accepted. No buffer writes occur while it is high.
- R11: A command, data-request or register-frame request that arrives while a frame is being written or a data phase is pending is ignored. It sets `proto_err_o`, which stays set until reset.
- R12: Status bits clear when 1 is written to the matching bit of `irq_clr_i`; a set in the same cycle wins. `irq_o` = OR of (`irq_sts_o` AND `irq_en_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | New command pulse |
| cmd_packet_i | input | 1 | Command is a packet command |
| cmd_write_i | input | 1 | Command moves data host to device |
| drq_start_i | input | 1 | Data-request block start pulse |
| drq_bytes_i | input | 16 | Byte count of the block |
| dev_status_i | input | 8 | Device status byte |
| dev_error_i | input | 8 | Device error byte |
| d2h_send_i | input | 1 | Register-frame request pulse |
| data_done_i | input | 1 | Data phase of the current block finished |
| irq_en_i | input | 3 | Interrupt enable per status bit |
| irq_clr_i | input | 3 | Write-1-to-clear strobes |
| fbuf_we_o | output | 1 | Frame buffer byte write enable |
| fbuf_addr_o | output | 8 | Frame buffer byte address |
| fbuf_data_o | output | 8 | Frame buffer byte data |
| data_req_o | output | 1 | Data phase pending |
| irq_sts_o | output | 3 | Status bits: 0 register frame, 1 PIO setup done, 2 task-file error |
| irq_o | output | 1 | Port interrupt line |
| proto_err_o | output | 1 | Sticky protocol error |
| xfer_count_o | output | 32 | Bytes transferred in the current command |

## Verification
On every cycle the assertions check four things: buffer writes advance by exactly one address until a frame's last byte, no write overlaps a pending data phase, the protocol-error flag never drops, and set status bits survive unless cleared. They also check that the PIO-done bit can only rise after an accepted data phase. Only the bench's scenarios can show that the interrupt flag follows the command type and the finished-block history. The same holds for the skipped packet block, for the flag being reset by a new command, and for requests made while busy leaving the buffer, count and status untouched.

// File: rtl/pio_fis_pkg.sv
package pio_fis_pkg;
  localparam int FIS_LEN  = 20;
  localparam int IDX_W    = $clog2(FIS_LEN);
  localparam int BCNT_W   = 16;
  localparam int IRQ_N    = 3;
  localparam int IRQ_DHRS = 0;
  localparam int IRQ_PSS  = 1;
  localparam int IRQ_TFES = 2;
  localparam int STS_ERR  = 0;
  localparam int IFLAG    = 6;
  localparam logic [7:0] CODE_PIO = 8'h5F;
  localparam logic [7:0] CODE_D2H = 8'h34;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_DATA} seq_state_e;
  typedef enum logic {FIS_PIO, FIS_D2H} fis_kind_e;

  typedef struct packed {
    fis_kind_e         kind;
    logic              iflag;
    logic [7:0]        status;
    logic [7:0]        error;
    logic [BCNT_W-1:0] bytes;
  } fis_fields_t;
endpackage

// File: rtl/pio_fis_fmt.sv
module pio_fis_fmt
  import pio_fis_pkg::*;
(
  input  fis_fields_t       fields_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o
);
  always_comb begin
    byte_o = 8'h00;
    case (int'(idx_i))
      0: byte_o = (fields_i.kind == FIS_PIO) ? CODE_PIO : CODE_D2H;
      1: byte_o = 8'(fields_i.iflag) << IFLAG;
      2: byte_o = fields_i.status;
      3: byte_o = fields_i.error;
      16: if (fields_i.kind == FIS_PIO) byte_o = fields_i.bytes[7:0];
      17: if (fields_i.kind == FIS_PIO) byte_o = fields_i.bytes[15:8];
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pio_fis_ctl.sv
module pio_fis_ctl
  import pio_fis_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic              cmd_packet_i,
  input  logic              cmd_write_i,
  input  logic              drq_start_i,
  input  logic [BCNT_W-1:0] drq_bytes_i,
  input  logic [7:0]        dev_status_i,
  input  logic [7:0]        dev_error_i,
  input  logic              d2h_send_i,
  input  logic              data_done_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output fis_fields_t       fields_o,
  output logic              data_req_o,
  output logic [IRQ_N-1:0]  evt_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              proto_err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIS_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  fis_fields_t      fields_q, fields_d;
  logic             ld_fields;
  logic             skip_q, skip_d;
  logic             first_q, first_d;
  logic             pkt_q, pkt_d;
  logic             wrt_q, wrt_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             err_q, err_d;
  logic             any_req;

  assign any_req = cmd_start_i | drq_start_i | d2h_send_i;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    fields_d  = fields_q;
    ld_fields = 1'b0;
    skip_d    = skip_q;
    first_d   = first_q;
    pkt_d     = pkt_q;
    wrt_d     = wrt_q;
    count_d   = count_q;
    err_d     = err_q | ((state_q != ST_IDLE) & any_req);
    evt_o     = '0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_start_i) begin
          first_d = 1'b0;
          pkt_d   = cmd_packet_i;
          wrt_d   = cmd_write_i;
          count_d = '0;
        end else if (drq_start_i) begin
          ld_fields = 1'b1;
          fields_d  = '{kind: FIS_PIO, iflag: first_q | (~pkt_q & ~wrt_q),
                        status: dev_status_i, error: dev_error_i, bytes: drq_bytes_i};
          skip_d    = pkt_q & ~first_q;
          idx_d     = '0;
          state_d   = ST_WRITE;
        end else if (d2h_send_i) begin
          ld_fields = 1'b1;
          fields_d  = '{kind: FIS_D2H, iflag: 1'b1, status: dev_status_i,
                        error: dev_error_i, bytes: '0};
          idx_d     = '0;
          state_d   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == LAST_IDX) begin
          idx_d = '0;
          if (fields_q.kind == FIS_PIO) begin
            evt_o[IRQ_TFES] = fields_q.status[STS_ERR];
            if (skip_q) begin
              first_d = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_DATA;
            end
          end else begin
            evt_o[IRQ_DHRS] = 1'b1;
            state_d         = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (data_done_i) begin
          count_d        = count_q + CNT_W'(fields_q.bytes);
          first_d        = 1'b1;
          evt_o[IRQ_PSS] = fields_q.iflag;
          state_d        = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      fields_q <= '0;
      skip_q   <= 1'b0;
      first_q  <= 1'b0;
      pkt_q    <= 1'b0;
      wrt_q    <= 1'b0;
      count_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      skip_q  <= skip_d;
      first_q <= first_d;
      pkt_q   <= pkt_d;
      wrt_q   <= wrt_d;
      count_q <= count_d;
      err_q   <= err_d;
      if (ld_fields) fields_q <= fields_d;
    end
  end

  assign wr_en_o     = (state_q == ST_WRITE);
  assign wr_idx_o    = idx_q;
  assign fields_o    = fields_q;
  assign data_req_o  = (state_q == ST_DATA);
  assign count_o     = count_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/pio_fis_irq.sv
module pio_fis_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic nxt;
    assign nxt = set_i[g] | (sts_q[g] & ~clr_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[g] <= 1'b0;
      else        sts_q[g] <= nxt;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);
endmodule

// File: rtl/pio_fis_seq.sv
module pio_fis_seq
  import pio_fis_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PSFIS_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] RFIS_BASE  = 8'h40,
  parameter int                CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic              cmd_packet_i,
  input  logic              cmd_write_i,
  input  logic              drq_start_i,
  input  logic [15:0]       drq_bytes_i,
  input  logic [7:0]        dev_status_i,
  input  logic [7:0]        dev_error_i,
  input  logic              d2h_send_i,
  input  logic              data_done_i,
  input  logic [2:0]        irq_en_i,
  input  logic [2:0]        irq_clr_i,
  output logic              fbuf_we_o,
  output logic [ADDR_W-1:0] fbuf_addr_o,
  output logic [7:0]        fbuf_data_o,
  output logic              data_req_o,
  output logic [2:0]        irq_sts_o,
  output logic              irq_o,
  output logic              proto_err_o,
  output logic [CNT_W-1:0]  xfer_count_o
);
  logic [IDX_W-1:0] wr_idx;
  fis_fields_t      fields;
  logic [IRQ_N-1:0] evt;

  pio_fis_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk, .rst_n, .cmd_start_i, .cmd_packet_i, .cmd_write_i,
    .drq_start_i, .drq_bytes_i, .dev_status_i, .dev_error_i,
    .d2h_send_i, .data_done_i,
    .wr_en_o(fbuf_we_o), .wr_idx_o(wr_idx), .fields_o(fields),
    .data_req_o, .evt_o(evt), .count_o(xfer_count_o), .proto_err_o
  );

  pio_fis_fmt fmt_i (.fields_i(fields), .idx_i(wr_idx), .byte_o(fbuf_data_o));

  assign fbuf_addr_o = ((fields.kind == FIS_PIO) ? PSFIS_BASE : RFIS_BASE)
                     + ADDR_W'(wr_idx);

  pio_fis_irq #(.N(IRQ_N)) irq_i (
    .clk, .rst_n, .set_i(evt), .clr_i(irq_clr_i), .en_i(irq_en_i),
    .sts_o(irq_sts_o), .irq_o
  );
endmodule

// File: rtl/pio_fis_seq_chk.sv
module pio_fis_seq_chk #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PSFIS_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] RFIS_BASE  = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_done_i,
  input logic [2:0]        irq_clr_i,
  input logic              fbuf_we_o,
  input logic [ADDR_W-1:0] fbuf_addr_o,
  input logic              data_req_o,
  input logic [2:0]        irq_sts_o,
  input logic              proto_err_o
);
  localparam logic [ADDR_W-1:0] PS_LAST = PSFIS_BASE + ADDR_W'(19);
  localparam logic [ADDR_W-1:0] RF_LAST = RFIS_BASE + ADDR_W'(19);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fbuf_we_o && fbuf_addr_o != PS_LAST && fbuf_addr_o != RF_LAST)
      |=> (fbuf_we_o && fbuf_addr_o == $past(fbuf_addr_o) + ADDR_W'(1)));

  a_r10_no_write_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_req_o |-> !fbuf_we_o);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  a_r5_pss_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts_o[1]) |-> $past(data_req_o && data_done_i));

  a_r12_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_sts_o & $past(irq_sts_o & ~irq_clr_i)) == $past(irq_sts_o & ~irq_clr_i)));
endmodule

bind pio_fis_seq pio_fis_seq_chk #(
  .ADDR_W(ADDR_W), .PSFIS_BASE(PSFIS_BASE), .RFIS_BASE(RFIS_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .data_done_i(data_done_i), .irq_clr_i(irq_clr_i),
  .fbuf_we_o(fbuf_we_o), .fbuf_addr_o(fbuf_addr_o), .data_req_o(data_req_o),
  .irq_sts_o(irq_sts_o), .proto_err_o(proto_err_o)
);

// File: tb/pio_fis_seq_tb_top.sv
module pio_fis_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 32'h20;
  localparam int RF = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start_i = 0, cmd_packet_i = 0, cmd_write_i = 0;
  logic drq_start_i = 0;
  logic [15:0] drq_bytes_i = 0;
  logic [7:0] dev_status_i = 0, dev_error_i = 0;
  logic d2h_send_i = 0, data_done_i = 0;
  logic [2:0] irq_en_i = 0, irq_clr_i = 0;
  logic fbuf_we_o;
  logic [7:0] fbuf_addr_o, fbuf_data_o;
  logic data_req_o, irq_o, proto_err_o;
  logic [2:0] irq_sts_o;
  logic [31:0] xfer_count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_fis_seq dut_i (.*);

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] mem [0:255];

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int q[$];
  int m_kind, m_i, m_skip, m_first, m_pkt, m_wr, m_st, m_bytes;
  int m_dphase, m_err, m_sts, m_count;

  function automatic int fis_byte(int kind, int iflag, int st, int er, int bytes, int b);
    if (b == 0) return (kind == 0) ? 8'h5F : 8'h34;
    if (b == 1) return iflag ? 8'h40 : 0;
    if (b == 2) return st;
    if (b == 3) return er;
    if (kind == 0 && b == 16) return bytes & 8'hFF;
    if (kind == 0 && b == 17) return (bytes >> 8) & 8'hFF;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_kind = 0; m_i = 0; m_skip = 0; m_first = 0; m_pkt = 0; m_wr = 0;
      m_st = 0; m_bytes = 0; m_dphase = 0; m_err = 0; m_sts = 0; m_count = 0;
    end else begin
      automatic int busy = (q.size() != 0) || m_dphase;
      automatic int set = 0;
      if (q.size() != 0) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          if (m_kind == 0) begin
            if (m_st & 1) set |= 4;
            if (m_skip) m_first = 1; else m_dphase = 1;
          end else set |= 1;
        end
      end else if (m_dphase && data_done_i) begin
        m_count += m_bytes; m_first = 1; m_dphase = 0;
        if (m_i) set |= 2;
      end
      if (busy) begin
        if (cmd_start_i || drq_start_i || d2h_send_i) m_err = 1;
      end else if (cmd_start_i) begin
        m_first = 0; m_pkt = cmd_packet_i; m_wr = cmd_write_i; m_count = 0;
      end else if (drq_start_i || d2h_send_i) begin
        m_kind = drq_start_i ? 0 : 1;
        m_i = drq_start_i ? (m_first || (!m_pkt && !m_wr)) : 1;
        if (drq_start_i) m_skip = m_pkt && !m_first;
        m_st = dev_status_i; m_bytes = drq_start_i ? drq_bytes_i : 0;
        for (int b = 0; b < 20; b++)
          q.push_back((((m_kind == 0 ? PS : RF) + b) << 8)
                      | fis_byte(m_kind, m_i, dev_status_i, dev_error_i, m_bytes, b));
      end
      m_sts = (m_sts & ~irq_clr_i) | set;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int exp_we = (q.size() != 0);
      chk("R2 write enable", fbuf_we_o, exp_we);
      if (exp_we && fbuf_we_o) begin
        chk(m_kind == 0 ? "R2 addr" : "R7 addr", fbuf_addr_o, (q[0] >> 8) & 8'hFF);
        chk(m_kind == 0 ? "R2 data" : "R7 data", fbuf_data_o, q[0] & 8'hFF);
      end
      if (fbuf_we_o) mem[fbuf_addr_o] = fbuf_data_o;
      chk("R12 status", irq_sts_o, m_sts);
      chk("R12 irq line", irq_o, ((m_sts & irq_en_i) != 0) ? 1 : 0);
      chk("R10 data_req", data_req_o, m_dphase);
      chk("R11 proto_err", proto_err_o, m_err);
      chk("R8 count", xfer_count_o, m_count);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cmd(logic pkt, logic wr);
    cmd_start_i = 1; cmd_packet_i = pkt; cmd_write_i = wr;
    tick(); cmd_start_i = 0;
  endtask

  task automatic drq(int bytes, int st, int er);
    drq_start_i = 1; drq_bytes_i = 16'(bytes); dev_status_i = 8'(st); dev_error_i = 8'(er);
    tick(); drq_start_i = 0;
    repeat (22) tick();
  endtask

  task automatic d2h(int st, int er);
    d2h_send_i = 1; dev_status_i = 8'(st); dev_error_i = 8'(er);
    tick(); d2h_send_i = 0;
    repeat (22) tick();
  endtask

  task automatic finish_data();
    while (!data_req_o) tick();
    data_done_i = 1; tick(); data_done_i = 0; tick();
  endtask

  task automatic clear(int bits);
    irq_clr_i = 3'(bits); tick(); irq_clr_i = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (3) tick();
    // R1 reset state
    chk("R1 we", fbuf_we_o, 0); chk("R1 sts", irq_sts_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 req", data_req_o, 0); chk("R1 err", proto_err_o, 0); chk("R1 count", xfer_count_o, 0);
    rst_n = 1; tick();
    chk("R1 after release", {fbuf_we_o, data_req_o, irq_sts_o, proto_err_o}, 0);

    // non-packet read: flag set, PSS after data
    cmd(0, 0);
    drq(512, 8'h58, 0);
    chk("R2 type", mem[PS], 8'h5F); chk("R3 read flag", mem[PS+1], 8'h40);
    chk("R2 status", mem[PS+2], 8'h58); chk("R2 count lo", mem[PS+16], 8'h00);
    chk("R2 count hi", mem[PS+17], 8'h02); chk("R2 pad", mem[PS+5], 8'h00);
    chk("R5 no PSS before data", irq_sts_o[1], 0);
    finish_data();
    chk("R5 PSS after data", irq_sts_o[1], 1); chk("R8 count", xfer_count_o, 512);
    clear(2); chk("R12 cleared", irq_sts_o, 0);

    // non-packet write: first block flag clear, later blocks set
    cmd(0, 1);
    chk("R8 cleared", xfer_count_o, 0);
    drq(256, 8'h58, 0); chk("R3 write first", mem[PS+1], 8'h00);
    finish_data(); chk("R5 no PSS flag clear", irq_sts_o[1], 0);
    drq(256, 8'h58, 0); chk("R3 write second", mem[PS+1], 8'h40);
    finish_data(); chk("R5 PSS second", irq_sts_o[1], 1); chk("R8 sum", xfer_count_o, 512);
    clear(2);

    // packet read: first block skipped
    cmd(1, 0);
    drq(12, 8'h58, 0);
    chk("R4 packet flag", mem[PS+1], 8'h00); chk("R4 no data phase", data_req_o, 0);
    chk("R4 count", xfer_count_o, 0); chk("R4 no PSS", irq_sts_o[1], 0);
    drq(2048, 8'h58, 0); chk("R3 packet data flag", mem[PS+1], 8'h40);
    finish_data(); chk("R8 packet count", xfer_count_o, 2048); chk("R5 packet PSS", irq_sts_o[1], 1);
    clear(2);

    // new packet write command: flag cleared again
    cmd(1, 1);
    drq(12, 8'h58, 0); chk("R9 flag reset", mem[PS+1], 8'h00);
    drq(16, 8'h51, 8'h04); chk("R9 flag set after skip", mem[PS+1], 8'h40);
    chk("R6 TFES", irq_sts_o[2], 1); chk("R2 error", mem[PS+3], 8'h04);
    // R11: request during pending data phase is ignored
    drq_start_i = 1; drq_bytes_i = 100; dev_status_i = 8'h11; tick(); drq_start_i = 0;
    tick(); chk("R11 err", proto_err_o, 1); chk("R11 no write", fbuf_we_o, 0);
    finish_data(); chk("R11 count unaffected", xfer_count_o, 16);
    chk("R11 status byte kept", mem[PS+2], 8'h51);
    clear(6); chk("R11 sticky", proto_err_o, 1);

    // register frame
    irq_en_i = 3'b001;
    d2h(8'h50, 8'h00);
    chk("R7 type", mem[RF], 8'h34); chk("R7 flag", mem[RF+1], 8'h40);
    chk("R7 status", mem[RF+2], 8'h50); chk("R7 DHRS", irq_sts_o[0], 1);
    chk("R12 line on", irq_o, 1);
    irq_en_i = 3'b110; tick(); chk("R12 masked", irq_o, 0);
    clear(1); chk("R12 clear", irq_sts_o, 0);

    repeat (4) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule